// File: doc/BRIEF.md
# Two-Level Periodic Interrupt Timer

This block produces periodic interrupt requests on several independent channels. Timing is built in two stages. A small set of shared 8-bit prescalers (micro timers) each divide the module clock into a tick stream. Every channel has a 16-bit down-counter that counts ticks from one micro timer, chosen by a per-channel select field. When a channel's counter expires it reloads, raises a sticky timeout flag and, if its interrupt enable is set, drives its request line.

Software uses the block in a fixed way. It writes the load values, the select fields and the enables while the global run bit is 0, in any order. It then sets the run bit. It clears flags by writing ones to the flag register. Turning off a channel, its interrupt enable or the global run bit also discards the affected pending flags. The register port is a plain synchronous write/read port with reads returned one cycle after the request.

Top module: `tlpit_top`

## Requirements
- R1: A micro timer with load value N ticks once every N+1 clock cycles while the global run bit is set; the first tick comes N+1 cycles after the run bit is written to 1.
- R2: A channel with load value M and channel enable set sets its flag once every M+1 ticks of its selected micro timer. From the run bit being written, the flag rises at (M+1)(N+1) cycles, and again at twice that if it was cleared in between.
- R3: Field i of the select register (one bit per channel, bit i, with the default two micro timers) picks the micro timer for channel i. 0 selects micro timer 0 and 1 selects micro timer 1.
- R4: Nothing counts and no flag sets while the global run bit (bit 0 of address 0) is 0. A channel counts only when both the run bit and its enable bit (bit i of address 1) are 1.
- R5: Writing address 4 clears each flag whose data bit is 1. Flags under a 0 data bit are unchanged.
- R6: A write that turns a channel's enable (address 1) or interrupt enable (address 2) from 1 to 0 clears that channel's flag. A write that turns the run bit from 1 to 0 clears all flags.
- R7: irq[i] is high exactly when flag i and interrupt enable bit i (address 2) are both 1. A flag still sets with its interrupt enable at 0 and is readable at address 4.
- R8: When a flag sets in the same cycle that a write-one-to-clear targets it, the flag ends up set.
- R9: After reset every register reads 0 and irq is 0. Registers read back what was written, one cycle after rd_en. The map is: 0 run bit, 1 channel enables, 2 interrupt enables, 3 select fields, 4 flags, 8+m micro-timer load m, 16+i channel load i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| irq | output | 4 | Per-channel interrupt request |

## Verification
The assertions assume a select field only ever names a micro timer that exists. They also assume a micro-timer count is never changed behind the prescaler's back, so a tick is always followed by a reload and any other running cycle by a decrement. The stimulus writes only select values 0 and 1. It writes load values, selects and enables only while the run bit is 0, except in the directed enable-drop tests, which act well away from any expiry. This keeps every flag-set event unambiguous with respect to clearing writes. The one case that deliberately overlaps the two is the priority test, where the channel expires every cycle.

// File: rtl/tlpit_pkg.sv
`timescale 1ns/1ps
package tlpit_pkg;
  // register addresses
  localparam int ADR_CTRL  = 0;
  localparam int ADR_CHEN  = 1;
  localparam int ADR_IRQEN = 2;
  localparam int ADR_SEL   = 3;
  localparam int ADR_FLAG  = 4;
  localparam int ADR_MTLD  = 8;
  localparam int ADR_CHLD  = 16;

  // width of a channel's micro-timer select field
  function automatic int sel_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tlpit_regs.sv
`timescale 1ns/1ps
module tlpit_regs import tlpit_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int NUM_MT = 2,
  parameter int MT_W   = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  localparam int SEL_W = sel_bits(NUM_MT)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [NUM_CH-1:0]                 flags,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              glb_en,
  output logic [NUM_CH-1:0]                 ch_en,
  output logic [NUM_CH-1:0]                 irq_en,
  output logic [NUM_CH-1:0][SEL_W-1:0]      ch_sel,
  output logic [NUM_MT-1:0][MT_W-1:0]       mt_load,
  output logic [NUM_CH-1:0][CNT_W-1:0]      ch_load,
  output logic [NUM_CH-1:0]                 w1c,
  output logic [NUM_CH-1:0]                 drop
);
  logic wr_ctrl, wr_chen, wr_irqen, wr_sel, wr_flag;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl  = wr_en && (addr == ADDR_W'(ADR_CTRL));
  assign wr_chen  = wr_en && (addr == ADDR_W'(ADR_CHEN));
  assign wr_irqen = wr_en && (addr == ADDR_W'(ADR_IRQEN));
  assign wr_sel   = wr_en && (addr == ADDR_W'(ADR_SEL));
  assign wr_flag  = wr_en && (addr == ADDR_W'(ADR_FLAG));

  // clear requests: explicit write-one-to-clear and 1->0 transitions of enables
  always_comb begin
    w1c  = wr_flag ? wr_data[NUM_CH-1:0] : '0;
    drop = '0;
    if (wr_chen)  drop = drop | (ch_en  & ~wr_data[NUM_CH-1:0]);
    if (wr_irqen) drop = drop | (irq_en & ~wr_data[NUM_CH-1:0]);
    if (wr_ctrl && glb_en && !wr_data[0]) drop = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en  <= 1'b0;
      ch_en   <= '0;
      irq_en  <= '0;
      ch_sel  <= '0;
      mt_load <= '0;
      ch_load <= '0;
    end else if (wr_en) begin
      if (wr_ctrl)  glb_en <= wr_data[0];
      if (wr_chen)  ch_en  <= wr_data[NUM_CH-1:0];
      if (wr_irqen) irq_en <= wr_data[NUM_CH-1:0];
      if (wr_sel) begin
        for (int i = 0; i < NUM_CH; i++) ch_sel[i] <= wr_data[i*SEL_W +: SEL_W];
      end
      for (int m = 0; m < NUM_MT; m++) begin
        if (addr == ADDR_W'(ADR_MTLD + m)) mt_load[m] <= wr_data[MT_W-1:0];
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == ADDR_W'(ADR_CHLD + i)) ch_load[i] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADR_CTRL))  rd_mux[0] = glb_en;
    if (addr == ADDR_W'(ADR_CHEN))  rd_mux[NUM_CH-1:0] = ch_en;
    if (addr == ADDR_W'(ADR_IRQEN)) rd_mux[NUM_CH-1:0] = irq_en;
    if (addr == ADDR_W'(ADR_FLAG))  rd_mux[NUM_CH-1:0] = flags;
    if (addr == ADDR_W'(ADR_SEL)) begin
      for (int i = 0; i < NUM_CH; i++) rd_mux[i*SEL_W +: SEL_W] = ch_sel[i];
    end
    for (int m = 0; m < NUM_MT; m++) begin
      if (addr == ADDR_W'(ADR_MTLD + m)) rd_mux[MT_W-1:0] = mt_load[m];
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(ADR_CHLD + i)) rd_mux[CNT_W-1:0] = ch_load[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/tlpit_mtimer.sv
`timescale 1ns/1ps
module tlpit_mtimer #(
  parameter int MT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [MT_W-1:0] load,
  output logic            tick,
  output logic [MT_W-1:0] cnt_o
);
  logic [MT_W-1:0] cnt;

  assign tick  = run && (cnt == '0);
  assign cnt_o = cnt;

  // idle: track the load value so a start always begins from a full period
  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (!run)          cnt <= load;
    else if (cnt == '0)     cnt <= load;
    else                    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/tlpit_chan.sv
`timescale 1ns/1ps
module tlpit_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             tick,
  input  logic [CNT_W-1:0] load,
  input  logic             w1c,
  input  logic             drop,
  input  logic             ie,
  output logic             set_evt,
  output logic             flag,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;

  assign set_evt = active && tick && (cnt == '0);
  assign irq     = flag & ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (!active)         cnt <= load;
      else if (tick)       cnt <= (cnt == '0) ? load : cnt - 1'b1;
      // a new expiry outranks any clear in the same cycle
      flag <= set_evt | (flag & ~w1c & ~drop);
    end
  end
endmodule

// File: rtl/tlpit_top.sv
`timescale 1ns/1ps
module tlpit_top import tlpit_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int NUM_MT = 2,
  parameter int MT_W   = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] irq
);
  localparam int SEL_W = sel_bits(NUM_MT);

  logic                          glb_en;
  logic [NUM_CH-1:0]             ch_en, irq_en, w1c, drop, flags, set_evt;
  logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel;
  logic [NUM_MT-1:0][MT_W-1:0]   mt_load, mt_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_load;
  logic [NUM_MT-1:0]             mt_tick;

  tlpit_regs #(
    .NUM_CH(NUM_CH), .NUM_MT(NUM_MT), .MT_W(MT_W),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .flags(flags), .rd_data(rd_data), .glb_en(glb_en),
    .ch_en(ch_en), .irq_en(irq_en), .ch_sel(ch_sel), .mt_load(mt_load),
    .ch_load(ch_load), .w1c(w1c), .drop(drop)
  );

  for (genvar gm = 0; gm < NUM_MT; gm++) begin : g_mt
    tlpit_mtimer #(.MT_W(MT_W)) u_mt (
      .clk(clk), .rst(rst), .run(glb_en), .load(mt_load[gm]),
      .tick(mt_tick[gm]), .cnt_o(mt_cnt[gm])
    );
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    logic sel_tick;
    assign sel_tick = (int'(ch_sel[gi]) < NUM_MT) ? mt_tick[ch_sel[gi]] : 1'b0;

    tlpit_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .active(glb_en & ch_en[gi]), .tick(sel_tick),
      .load(ch_load[gi]), .w1c(w1c[gi]), .drop(drop[gi]), .ie(irq_en[gi]),
      .set_evt(set_evt[gi]), .flag(flags[gi]), .irq(irq[gi])
    );
  end
endmodule

// File: rtl/tlpit_chk.sv
`timescale 1ns/1ps
module tlpit_chk import tlpit_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int NUM_MT = 2,
  parameter int MT_W   = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  localparam int SEL_W = sel_bits(NUM_MT)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            addr,
  input logic [DATA_W-1:0]            wr_data,
  input logic                         glb_en,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0]            irq_en,
  input logic [NUM_CH-1:0][SEL_W-1:0] ch_sel,
  input logic [NUM_MT-1:0][MT_W-1:0]  mt_load,
  input logic [NUM_MT-1:0][MT_W-1:0]  mt_cnt,
  input logic [NUM_MT-1:0]            mt_tick,
  input logic [NUM_CH-1:0]            set_evt,
  input logic [NUM_CH-1:0]            flags
);
  logic wr_flag;
  assign wr_flag = wr_en && (addr == ADDR_W'(ADR_FLAG));

  for (genvar m = 0; m < NUM_MT; m++) begin : g_m
    // R1
    mt_reload_chk: assert property (@(posedge clk) disable iff (rst)
      mt_tick[m] |=> (mt_cnt[m] == $past(mt_load[m])));
    // R1
    mt_step_chk: assert property (@(posedge clk) disable iff (rst)
      (glb_en && !mt_tick[m]) |=> (mt_cnt[m] == MT_W'($past(mt_cnt[m]) - 1'b1)));
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_c
    // R4
    active_only_chk: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |-> (glb_en && ch_en[i]));
    // R3
    sel_tick_chk: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |-> mt_tick[ch_sel[i]]);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> flags[i]);
    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_flag && wr_data[i] && !set_evt[i]) |=> !flags[i]);
    // R6
    ie_drop_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(irq_en[i]) && !$past(set_evt[i])) |-> !flags[i]);
    // R6
    en_drop_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(ch_en[i]) && !$past(set_evt[i])) |-> !flags[i]);
  end
endmodule

bind tlpit_top tlpit_chk #(
  .NUM_CH(NUM_CH), .NUM_MT(NUM_MT), .MT_W(MT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .glb_en(glb_en), .ch_en(ch_en), .irq_en(irq_en), .ch_sel(ch_sel),
  .mt_load(mt_load), .mt_cnt(mt_cnt), .mt_tick(mt_tick),
  .set_evt(set_evt), .flags(flags)
);

// File: tb/tlpit_top_bench.sv
`timescale 1ns/1ps
module tlpit_top_bench;
  localparam int A_CTRL = 0, A_CHEN = 1, A_IRQEN = 2, A_SEL = 3, A_FLAG = 4;
  localparam int A_MTLD = 8, A_CHLD = 16;

  typedef struct packed {
    logic [1:0]  ch;
    logic        sel;
    logic [7:0]  n0;
    logic [7:0]  n1;
    logic [15:0] m;
    logic [15:0] per;
  } vec_t;

  // channel, select, micro loads, channel load, expected period in cycles
  localparam vec_t VT [6] = '{
    '{2'd0, 1'b0, 8'd9,  8'd3,  16'd0, 16'd10},
    '{2'd1, 1'b0, 8'd4,  8'd50, 16'd3, 16'd20},
    '{2'd2, 1'b1, 8'd2,  8'd7,  16'd2, 16'd24},
    '{2'd3, 1'b1, 8'd30, 8'd0,  16'd5, 16'd6},
    '{2'd0, 1'b0, 8'd99, 8'd5,  16'd4, 16'd500},
    '{2'd3, 1'b1, 8'd1,  8'd19, 16'd0, 16'd20}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  irq;
  int cyc = 0, n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  tlpit_top u_tlpit_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wr_data = 16'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = 5'(a);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rd_data);
  endtask

  task automatic wait_irq(input int ch, input int lim, output int when);
    when = -1;
    for (int k = 0; k < lim; k++) begin
      if (irq[ch]) begin
        when = cyc;
        return;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int d, w, t_en;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R9 reset state
    rd(A_CTRL, d);     chk(d == 0, "R9 ctrl after reset", d, 0);
    rd(A_CHLD, d);     chk(d == 0, "R9 chan load after reset", d, 0);
    chk(irq == 4'h0, "R9 irq after reset", int'(irq), 0);

    // R9 readback
    wr(A_CHLD + 2, 16'hABCD);
    rd(A_CHLD + 2, d); chk(d == 16'hABCD, "R9 chan load readback", d, 16'hABCD);
    wr(A_SEL, 4'b1010);
    rd(A_SEL, d);      chk(d == 4'b1010, "R9 select readback", d, 4'b1010);

    // vector table: R1 tick spacing, R2 timeout spacing, R3 select
    for (int k = 0; k < 6; k++) begin
      vec_t v;
      string tag;
      v = VT[k];
      tag = v.sel ? "R3" : ((v.m == 0) ? "R1" : "R2");
      wr(A_CTRL, 0);
      wr(A_FLAG, 4'hF);
      wr(A_MTLD, int'(v.n0));
      wr(A_MTLD + 1, int'(v.n1));
      wr(A_SEL, int'(v.sel) << v.ch);
      wr(A_CHLD + int'(v.ch), int'(v.m));
      wr(A_CHEN, 1 << v.ch);
      wr(A_IRQEN, 1 << v.ch);
      wr(A_CTRL, 1);
      t_en = cyc;
      wait_irq(int'(v.ch), 3 * int'(v.per) + 20, w);
      chk(w - t_en == int'(v.per), {tag, " first timeout"}, w - t_en, int'(v.per));
      wr(A_FLAG, 1 << v.ch);
      wait_irq(int'(v.ch), 3 * int'(v.per) + 20, w);
      chk(w - t_en == 2 * int'(v.per), {tag, " second timeout"}, w - t_en, 2 * int'(v.per));
    end

    // R4: no counting while run bit is 0
    wr(A_CTRL, 0);
    wr(A_FLAG, 4'hF);
    wr(A_MTLD, 0);
    wr(A_SEL, 0);
    wr(A_CHLD, 0);
    wr(A_CHEN, 1);
    wr(A_IRQEN, 1);
    repeat (40) @(negedge clk);
    chk(irq == 4'h0, "R4 irq with run bit off", int'(irq), 0);
    rd(A_FLAG, d);     chk(d == 0, "R4 flags with run bit off", d, 0);

    // R7: flag sets without interrupt enable, request gated
    wr(A_IRQEN, 0);
    wr(A_CTRL, 1);
    repeat (10) @(negedge clk);
    chk(irq[0] == 1'b0, "R7 irq masked", int'(irq[0]), 0);
    rd(A_FLAG, d);     chk(d[0] == 1'b1, "R7 flag set while masked", d & 1, 1);
    wr(A_IRQEN, 1);
    chk(irq[0] == 1'b1, "R7 irq after unmask", int'(irq[0]), 1);

    // R8: channel expires every cycle, clear loses
    wr(A_FLAG, 1);
    chk(irq[0] == 1'b1, "R8 set beats clear", int'(irq[0]), 1);
    rd(A_FLAG, d);     chk(d[0] == 1'b1, "R8 flag after clear attempt", d & 1, 1);

    // R5: write-one-to-clear, zeros ignored
    wr(A_CTRL, 0);
    wr(A_MTLD, 99);
    wr(A_CHLD + 1, 4);
    wr(A_CHEN, 2);
    wr(A_IRQEN, 2);
    wr(A_CTRL, 1);
    wait_irq(1, 1200, w);
    wr(A_FLAG, 0);
    rd(A_FLAG, d);     chk(d == 2, "R5 zero write keeps flag", d, 2);
    wr(A_FLAG, 2);
    rd(A_FLAG, d);     chk(d == 0, "R5 one write clears flag", d, 0);

    // R6: channel enable drop
    wait_irq(1, 1200, w);
    wr(A_CHEN, 0);
    rd(A_FLAG, d);     chk(d == 0, "R6 channel enable drop", d, 0);
    wr(A_CHEN, 2);

    // R6: interrupt enable drop
    wait_irq(1, 1200, w);
    wr(A_IRQEN, 0);
    wr(A_IRQEN, 2);
    rd(A_FLAG, d);     chk(d == 0, "R6 interrupt enable drop", d, 0);
    chk(irq == 4'h0, "R6 irq after interrupt enable drop", int'(irq), 0);

    // R6: run bit drop
    wait_irq(1, 1200, w);
    wr(A_CTRL, 0);
    rd(A_FLAG, d);     chk(d == 0, "R6 run bit drop", d, 0);
    chk(irq == 4'h0, "R6 irq after run bit drop", int'(irq), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule